// File: doc/BRIEF.md
# Eight-bit Arithmetic and Logic Unit with Status Flags

This block computes one byte result from two byte operands under a four-bit operation code. The operations are addition with or without carry-in, three subtraction forms that differ in operand order and borrow handling, bitwise AND, OR and XOR, a nibble exchange, and rotations through the carry in both directions. The result output is combinational. It depends on the operands, the operation code and the carry currently held in the status register.

An 8-bit status register sits beside the datapath and holds five flags. On a clock edge where the flag-update enable is high, the flags that the selected operation owns are written. All other flags keep their value. Flags are never written while the enable is low. A surrounding datapath supplies the operands and stores the result. The status output feeds the carry back into the next add-with-carry, subtract-with-borrow or rotate.

Top module: `alu8_core`

## Requirements
- R1: Status bit 0 is carry (C), bit 1 is digit carry (DC), bit 2 is zero (Z), bit 3 is signed overflow (OV) and bit 4 is negative (N). Bits 7 to 5 always read 0. An active-low reset clears the whole status register to 0x00.
- R2: Code 0 gives src_a + src_b and code 1 gives src_a + src_b + C. C is set to the carry out of bit 7 and DC is set to the carry out of bit 3.
- R3: Code 2 gives src_a - src_b. Code 3 gives src_a - src_b - (1 - C). Code 4 gives src_b - src_a - (1 - C). For all three, C is 1 when the full subtraction needs no borrow, and DC is 1 when the low nibble needs no borrow.
- R4: For codes 0 to 4, OV is set when the true signed two's-complement value does not fit in 8 bits. For codes 0 to 7, 9 and 10, N takes result bit 7 and Z is set exactly when the result is 0x00.
- R5: Code 5 is AND, code 6 is OR and code 7 is XOR of the two operands. These codes update Z and N only, and leave C, DC and OV unchanged.
- R6: Code 8 returns src_a with its upper and lower 4-bit halves exchanged, and changes no flag.
- R7: Code 9 rotates left through carry: the result is {src_a[6:0], C}. The new C is src_a[7] and the new DC is src_a[3]. OV is unchanged.
- R8: Code 10 rotates right through carry: the result is {C, src_a[7:1]}. The new C is src_a[0] and the new DC is src_a[4]. OV is unchanged.
- R9: While flag_en is low, the status register does not change, whatever the operation.
- R10: Codes 11 to 15 return a result of 0x00 and change no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status register |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_a | input | 8 | First operand (minuend of codes 2 and 3, source of swap and rotates) |
| src_b | input | 8 | Second operand (minuend of code 4) |
| op_code | input | 4 | Operation select, encoding given in R2 to R10 |
| flag_en | input | 1 | Writes the status register at the next rising edge when high |
| result | output | 8 | Combinational result |
| status | output | 8 | Registered status flags |

## Verification
The bound checker watches on every cycle that the pad bits stay 0 and that the status holds while the enable is low. It also checks, on each edge after an update, that Z and N agree with the result that was on the output. It further checks that logic operations keep C, DC and OV, and that swap and undefined codes leave the status untouched. The arithmetic values of C, DC and OV can only be shown by the bench's sweeps, which run every operation code over all 256 values of one operand and a spread of the other. Those sweeps compare against a borrow and signed-range model with the carry chained across operations.

// File: rtl/alu8_pkg.sv
package alu8_pkg;

    localparam int STAT_W = 8;

    localparam int FLG_C  = 0;
    localparam int FLG_DC = 1;
    localparam int FLG_Z  = 2;
    localparam int FLG_OV = 3;
    localparam int FLG_N  = 4;

    typedef enum logic [3:0] {
        OP_ADD   = 4'd0,
        OP_ADDC  = 4'd1,
        OP_SUB   = 4'd2,
        OP_SUBB  = 4'd3,
        OP_RSUBB = 4'd4,
        OP_AND   = 4'd5,
        OP_OR    = 4'd6,
        OP_XOR   = 4'd7,
        OP_SWAP  = 4'd8,
        OP_RLC   = 4'd9,
        OP_RRC   = 4'd10
    } alu_op_e;

    typedef struct packed {
        logic wr_cdc;
        logic wr_ov;
        logic wr_zn;
        logic c;
        logic dc;
        logic ov;
    } flag_req_t;

endpackage

// File: rtl/alu8_adder.sv
module alu8_adder #(
    parameter int W = 8
) (
    input  logic [W-1:0] x,
    input  logic [W-1:0] y,
    input  logic         cin,
    output logic [W-1:0] sum,
    output logic         cout,
    output logic         hcout,
    output logic         ovf
);
    localparam int H  = W / 2;
    localparam int HU = W - H;

    logic [H:0]  low_sum;
    logic [HU:0] high_sum;

    // Split carry chain so the nibble carry is a real wire, not a recomputation.
    assign low_sum  = {1'b0, x[H-1:0]} + {1'b0, y[H-1:0]} + {{H{1'b0}}, cin};
    assign high_sum = {1'b0, x[W-1:H]} + {1'b0, y[W-1:H]} + {{HU{1'b0}}, low_sum[H]};

    assign sum   = {high_sum[HU-1:0], low_sum[H-1:0]};
    assign cout  = high_sum[HU];
    assign hcout = low_sum[H];
    assign ovf   = (x[W-1] == y[W-1]) && (sum[W-1] != x[W-1]);
endmodule

// File: rtl/alu8_shuffle.sv
module alu8_shuffle
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         cin,
    input  logic [3:0]   op,
    output logic [W-1:0] res,
    output logic         rot_c,
    output logic         rot_dc
);
    localparam int H = W / 2;

    always_comb begin
        res    = '0;
        rot_c  = 1'b0;
        rot_dc = 1'b0;
        case (op)
            OP_AND:  res = a & b;
            OP_OR:   res = a | b;
            OP_XOR:  res = a ^ b;
            OP_SWAP: res = {a[H-1:0], a[W-1:H]};
            OP_RLC: begin
                res    = {a[W-2:0], cin};
                rot_c  = a[W-1];
                rot_dc = a[H-1];
            end
            OP_RRC: begin
                res    = {cin, a[W-1:1]};
                rot_c  = a[0];
                rot_dc = a[H];
            end
            default: res = '0;
        endcase
    end
endmodule

// File: rtl/alu8_status.sv
module alu8_status
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  flag_req_t         req,
    input  logic [W-1:0]      res,
    output logic [STAT_W-1:0] status_q
);
    logic c_q, dc_q, z_q, ov_q, n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            c_q  <= 1'b0;
            dc_q <= 1'b0;
            z_q  <= 1'b0;
            ov_q <= 1'b0;
            n_q  <= 1'b0;
        end else if (en) begin
            if (req.wr_cdc) begin
                c_q  <= req.c;
                dc_q <= req.dc;
            end
            if (req.wr_ov) begin
                ov_q <= req.ov;
            end
            if (req.wr_zn) begin
                z_q <= ~|res;
                n_q <= res[W-1];
            end
        end
    end

    always_comb begin
        status_q         = '0;
        status_q[FLG_C]  = c_q;
        status_q[FLG_DC] = dc_q;
        status_q[FLG_Z]  = z_q;
        status_q[FLG_OV] = ov_q;
        status_q[FLG_N]  = n_q;
    end
endmodule

// File: rtl/alu8_core.sv
module alu8_core
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      src_a,
    input  logic [W-1:0]      src_b,
    input  logic [3:0]        op_code,
    input  logic              flag_en,
    output logic [W-1:0]      result,
    output logic [STAT_W-1:0] status
);
    logic         carry_in;
    logic [W-1:0] add_x, add_y, add_sum, shf_res;
    logic         add_ci, add_co, add_hco, add_ov;
    logic         rot_c, rot_dc;
    logic         is_arith;
    flag_req_t    req;

    assign carry_in = status[FLG_C];

    // Operand steering: subtraction is x + ~y + cin.
    always_comb begin
        add_x    = src_a;
        add_y    = src_b;
        add_ci   = 1'b0;
        is_arith = 1'b1;
        case (op_code)
            OP_ADD:   add_ci = 1'b0;
            OP_ADDC:  add_ci = carry_in;
            OP_SUB: begin
                add_y  = ~src_b;
                add_ci = 1'b1;
            end
            OP_SUBB: begin
                add_y  = ~src_b;
                add_ci = carry_in;
            end
            OP_RSUBB: begin
                add_x  = src_b;
                add_y  = ~src_a;
                add_ci = carry_in;
            end
            default: is_arith = 1'b0;
        endcase
    end

    alu8_adder #(.W(W)) adder_i (
        .x     (add_x),
        .y     (add_y),
        .cin   (add_ci),
        .sum   (add_sum),
        .cout  (add_co),
        .hcout (add_hco),
        .ovf   (add_ov)
    );

    alu8_shuffle #(.W(W)) shuffle_i (
        .a      (src_a),
        .b      (src_b),
        .cin    (carry_in),
        .op     (op_code),
        .res    (shf_res),
        .rot_c  (rot_c),
        .rot_dc (rot_dc)
    );

    assign result = is_arith ? add_sum : shf_res;

    always_comb begin
        req = '0;
        case (op_code)
            OP_ADD, OP_ADDC, OP_SUB, OP_SUBB, OP_RSUBB: begin
                req.wr_cdc = 1'b1;
                req.wr_ov  = 1'b1;
                req.wr_zn  = 1'b1;
                req.c      = add_co;
                req.dc     = add_hco;
                req.ov     = add_ov;
            end
            OP_AND, OP_OR, OP_XOR: req.wr_zn = 1'b1;
            OP_RLC, OP_RRC: begin
                req.wr_cdc = 1'b1;
                req.wr_zn  = 1'b1;
                req.c      = rot_c;
                req.dc     = rot_dc;
            end
            default: req = '0;
        endcase
    end

    alu8_status #(.W(W)) status_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .en       (flag_en),
        .req      (req),
        .res      (result),
        .status_q (status)
    );
endmodule

// File: rtl/alu8_core_chk.sv
module alu8_core_chk
    import alu8_pkg::*;
#(
    parameter int W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [W-1:0]      src_a,
    input logic [3:0]        op_code,
    input logic              flag_en,
    input logic [W-1:0]      result,
    input logic [STAT_W-1:0] status
);
    logic zn_op, keep_op, logic_op;
    assign zn_op    = (op_code <= OP_XOR) || (op_code == OP_RLC) || (op_code == OP_RRC);
    assign keep_op  = (op_code == OP_SWAP) || (op_code > OP_RRC);
    assign logic_op = (op_code == OP_AND) || (op_code == OP_OR) || (op_code == OP_XOR);

    a_r1_pad_zero: assert property (@(posedge clk) disable iff (!rst_n)
        status[STAT_W-1:FLG_N+1] == '0);

    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !flag_en |=> $stable(status));

    a_r4_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && zn_op) |=> status[FLG_Z] == ($past(result) == '0));

    a_r4_neg: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && zn_op) |=> status[FLG_N] == $past(result[W-1]));

    a_r5_logic_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && logic_op) |=> (status[FLG_C] == $past(status[FLG_C]))
                                && (status[FLG_DC] == $past(status[FLG_DC]))
                                && (status[FLG_OV] == $past(status[FLG_OV])));

    a_r6_swap_keep: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && keep_op) |=> $stable(status));

    a_r10_undef_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (op_code > OP_RRC) |-> result == '0);

    a_r7_rlc_carry: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_en && op_code == OP_RLC) |=> status[FLG_C] == $past(src_a[W-1]));
endmodule

bind alu8_core alu8_core_chk #(.W(W)) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .src_a   (src_a),
    .op_code (op_code),
    .flag_en (flag_en),
    .result  (result),
    .status  (status)
);

// File: tb/alu8_core_tb.sv
module alu8_core_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] src_a = 8'h00;
    logic [7:0] src_b = 8'h00;
    logic [3:0] op_code = 4'd0;
    logic       flag_en = 1'b0;
    logic [7:0] result;
    logic [7:0] status;

    int n_chk = 0;
    int n_bad = 0;
    logic [7:0] m_st = 8'h00;

    always #5 clk = ~clk;

    alu8_core dut_i (
        .clk(clk), .rst_n(rst_n), .src_a(src_a), .src_b(src_b),
        .op_code(op_code), .flag_en(flag_en), .result(result), .status(status)
    );

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %02h expected %02h (op %0d a %02h b %02h)",
                     tag, what, act, exp, op_code, src_a, src_b);
        end
    endtask

    function automatic string tag_of(input int op);
        case (op)
            0, 1: return "R2";
            2, 3, 4: return "R3";
            5, 6, 7: return "R5";
            8: return "R6";
            9: return "R7";
            10: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Expected model: returns {result, next status}
    function automatic logic [15:0] model(input int a, input int b, input int op,
                                          input logic [7:0] st, input logic en);
        int c, r, sa, sb, sr, bw;
        logic fc, fdc, fz, fov, fn;
        logic wc, wov, wzn;
        c = st[0];
        fc = st[0]; fdc = st[1]; fz = st[2]; fov = st[3]; fn = st[4];
        wc = 0; wov = 0; wzn = 0;
        sa = (a > 127) ? a - 256 : a;
        sb = (b > 127) ? b - 256 : b;
        r = 0;
        case (op)
            0, 1: begin
                bw = (op == 1) ? c : 0;
                r = a + b + bw;
                fc = (r > 255);
                fdc = ((a % 16) + (b % 16) + bw) > 15;
                sr = sa + sb + bw;
                fov = (sr > 127) || (sr < -128);
                wc = 1; wov = 1; wzn = 1;
            end
            2, 3: begin
                bw = (op == 2) ? 0 : 1 - c;
                r = a - b - bw;
                fc = (a >= b + bw);
                fdc = ((a % 16) >= (b % 16) + bw);
                sr = sa - sb - bw;
                fov = (sr > 127) || (sr < -128);
                wc = 1; wov = 1; wzn = 1;
            end
            4: begin
                bw = 1 - c;
                r = b - a - bw;
                fc = (b >= a + bw);
                fdc = ((b % 16) >= (a % 16) + bw);
                sr = sb - sa - bw;
                fov = (sr > 127) || (sr < -128);
                wc = 1; wov = 1; wzn = 1;
            end
            5: begin r = a & b; wzn = 1; end
            6: begin r = a | b; wzn = 1; end
            7: begin r = a ^ b; wzn = 1; end
            8: r = (a % 16) * 16 + a / 16;
            9: begin
                r = (a * 2) % 256 + c;
                fc = (a / 128) % 2; fdc = (a / 8) % 2; wc = 1; wzn = 1;
            end
            10: begin
                r = c * 128 + a / 2;
                fc = a % 2; fdc = (a / 16) % 2; wc = 1; wzn = 1;
            end
            default: r = 0;
        endcase
        r = ((r % 256) + 256) % 256;
        if (wzn) begin fz = (r == 0); fn = (r > 127); end
        if (!en) return {r[7:0], st};
        return {r[7:0], 3'b000, fn, fov, fz, fdc, fc};
    endfunction

    task automatic apply(input int a, input int b, input int op, input logic en, input string tag);
        logic [15:0] m;
        @(negedge clk);
        src_a = a[7:0]; src_b = b[7:0]; op_code = op[3:0]; flag_en = en;
        m = model(a, b, op, m_st, en);
        #2;
        check(tag, "result", result, m[15:8]);
        @(posedge clk);
        #1;
        m_st = m[7:0];
        check(en ? tag : "R9", "status", status, m_st);
    endtask

    initial begin
        #1_500_000;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #2;
        check("R1", "reset status", status, 8'h00);
        rst_n = 1'b1;

        // Directed corners
        apply(8'h7F, 8'h01, 0, 1'b1, "R4");   // signed overflow, N=1, DC=1
        check("R4", "ovf flags", status, 8'h1A);
        apply(8'hFF, 8'h01, 0, 1'b1, "R2");   // zero with carry out
        check("R2", "carry zero", status, 8'h07);
        apply(8'h00, 8'h01, 2, 1'b1, "R3");   // borrow clears C and DC
        check("R3", "borrow", status, 8'h10);
        apply(8'h80, 8'h00, 9, 1'b1, "R7");   // rotate left drops bit 7 into C
        check("R7", "rlc", status, 8'h05);
        apply(8'h01, 8'h00, 10, 1'b1, "R8");  // C=1 in, bit 0 out
        apply(8'h5A, 8'hFF, 8, 1'b1, "R6");
        apply(8'h12, 8'h34, 13, 1'b1, "R10");
        apply(8'h00, 8'h00, 0, 1'b0, "R9");

        // Sweep every code over all src_a and a spread of src_b
        for (int op = 0; op < 16; op++) begin
            for (int a = 0; a < 256; a++) begin
                for (int b = 0; b < 256; b += 17) begin
                    apply(a, b, op, ((a ^ b) & 7) != 0, tag_of(op));
                end
            end
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule